// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the external bus master of an 8-bit processor. It places the low byte of a 16-bit address on a shared 8-bit address/data bus and the high byte on a separate output. A latch strobe frames the address phase, and active-low read and write strobes frame the data phase. A wait input lets a slow device lengthen the data phase. Inside the chip, a requester presents an address, write data and a direction flag with a request line. It gets back a one-cycle ready pulse and, for reads, the captured byte.

The block runs on a clock of twice the oscillator frequency, so one clock tick is half an oscillator period. A free-running counter makes a bus clock output of eight ticks, which is four oscillator periods. Every bus cycle begins on a rising edge of that bus clock. Each bus cycle has four segments: a latch strobe of two ticks, one tick of address hold, a strobe of four ticks, and one recovery tick. Each wait sample that is found high adds a whole bus-clock period to the strobe.

Top module: `busctl_mux`

## Requirements
- R1: While reset is low, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `ready` is 0.
- R2: `busclk` repeats every 8 ticks: high for 4 ticks, then low for 4 ticks.
- R3: A bus cycle opens with `ale` high for exactly 2 ticks. During those ticks `ad_oe`=1 and `ad_out` carries address bits [7:0]. `addr_hi` carries address bits [15:8] from the opening tick until the strobe is released.
- R4: In the tick after `ale` falls, `ad_out` still drives address bits [7:0] with `ad_oe`=1, and both strobes are still high.
- R5: The strobe falls 1 tick after `ale` falls and lasts 4 ticks when no wait is seen. `we`=1 selects `wr_n`, `we`=0 selects `rd_n`, and the two strobes are never low together.
- R6: In a write, `ad_out` carries the write byte with `ad_oe`=1 for every tick of `wr_n` low and for the one tick after `wr_n` rises.
- R7: In a read, `ad_oe` is 0 while `rd_n` is low and in the tick after. `rdata` holds the `ad_in` value present in the last tick before `rd_n` rises.
- R8: `bus_wait` is sampled at each falling edge of `busclk` while a strobe is low. Each sample found at 1 lengthens the strobe by 8 ticks, so the width is 4 + 8 × (samples found high).
- R9: `ready` is high for exactly one tick, in the tick after the recovery tick (1 tick after the strobe rises). `ale` stays low in the recovery tick.
- R10: `ale` rises only together with a rising edge of `busclk`, however the request is timed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request; held with its fields until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write byte |
| bus_wait | input | 1 | Stretch request from the addressed device |
| ad_in | input | 8 | Shared bus value as seen at the pads |
| ad_out | output | 8 | Value driven onto the shared bus |
| ad_oe | output | 1 | Drive enable of the shared bus (0 = released) |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busclk | output | 1 | Bus clock phase output |
| ready | output | 1 | One-tick completion pulse |
| rdata | output | 8 | Byte captured by the last read |

## Verification
A phase counter that slips shows at once as a `busclk` edge out of step. Within the same bus period, `ale` or a strobe also lands a tick early or late. A sequencer that leaves its states at the wrong point changes a strobe width or the latch-to-strobe gap, and that shows in the very cycle it happens. A wrong wait sample shows as a strobe that is 8 ticks longer or shorter than expected. A capture at the wrong edge appears as a wrong `rdata` when `ready` pulses, because the device model drives the bus only while `rd_n` is low.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LATCH,
    S_HOLD,
    S_STROBE,
    S_RECOV
  } bus_state_e;

  // index of the last tick of a segment that starts at 'first' and lasts 'len'
  function automatic int unsigned seg_last(input int unsigned first, input int unsigned len);
    return first + len - 1;
  endfunction

  // strobe width in ticks for a given number of wait samples found high
  function automatic int unsigned strobe_ticks(input int unsigned base, input int unsigned period,
                                               input int unsigned waits);
    return base + period * waits;
  endfunction

endpackage

// File: rtl/busctl_phase.sv
module busctl_phase #(
  parameter int BUS_T = 8,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          busclk,
  output logic          period_end,
  output logic          wait_smp
);
  localparam int HALF = BUS_T / 2;

  assign period_end = (phase == PW'(BUS_T - 1));
  assign wait_smp   = (phase == PW'(HALF - 1));
  assign busclk     = (phase < PW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (period_end) phase <= '0;
    else                 phase <= phase + 1'b1;
  end

  // R2
  busclk_fall_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_smp |=> $fell(busclk));

endmodule

// File: rtl/busctl_seq.sv
module busctl_seq
  import busctl_pkg::*;
#(
  parameter int ALE_T  = 2,
  parameter int HOLD_T = 1,
  parameter int STB_T  = 4,
  parameter int PW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic          period_end,
  input  logic          wait_smp,
  input  logic          req,
  input  logic          we,
  input  logic [15:0]   addr,
  input  logic [7:0]    wdata,
  input  logic          bus_wait,
  output bus_state_e    state,
  output logic          we_q,
  output logic [15:0]   addr_q,
  output logic [7:0]    wdata_q,
  output logic          ready,
  output logic          rd_capture
);
  localparam int LATCH_END = seg_last(0, ALE_T);
  localparam int HOLD_END  = seg_last(ALE_T, HOLD_T);
  localparam int STB_END   = seg_last(ALE_T + HOLD_T, STB_T);

  logic stretch;
  logic stretch_eff;
  logic at_latch_end, at_hold_end, at_stb_end;
  logic strobe_release;

  assign at_latch_end   = (phase == PW'(LATCH_END));
  assign at_hold_end    = (phase == PW'(HOLD_END));
  assign at_stb_end     = (phase == PW'(STB_END));
  assign stretch_eff    = wait_smp ? bus_wait : stretch;
  assign strobe_release = (state == S_STROBE) && at_stb_end && !stretch_eff;
  assign rd_capture     = strobe_release && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stretch <= 1'b0;
      ready   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ready <= 1'b0;
      case (state)
        S_IDLE: if (req && period_end) begin
          state   <= S_LATCH;
          we_q    <= we;
          addr_q  <= addr;
          wdata_q <= wdata;
          stretch <= 1'b0;
        end
        S_LATCH: if (at_latch_end) state <= S_HOLD;
        S_HOLD:  if (at_hold_end)  state <= S_STROBE;
        S_STROBE: begin
          if (wait_smp) stretch <= bus_wait;
          if (strobe_release) state <= S_RECOV;
        end
        S_RECOV: if (period_end) begin
          state <= S_IDLE;
          ready <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

endmodule

// File: rtl/busctl_pad.sv
module busctl_pad
  import busctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  bus_state_e  state,
  input  logic        we_q,
  input  logic [15:0] addr_q,
  input  logic [7:0]  wdata_q,
  input  logic        rd_capture,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  rdata
);
  logic data_phase;

  assign data_phase = (state == S_STROBE) || (state == S_RECOV);
  assign ale        = (state == S_LATCH);
  assign rd_n       = !((state == S_STROBE) && !we_q);
  assign wr_n       = !((state == S_STROBE) && we_q);
  assign addr_hi    = addr_q[15:8];

  always_comb begin
    ad_out = 8'h00;
    ad_oe  = 1'b0;
    if ((state == S_LATCH) || (state == S_HOLD)) begin
      ad_out = addr_q[7:0];
      ad_oe  = 1'b1;
    end else if (data_phase && we_q) begin
      ad_out = wdata_q;
      ad_oe  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= ad_in;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (rd_n && wr_n && ad_oe));

  // R7
  read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

endmodule

// File: rtl/busctl_mux.sv
module busctl_mux
  import busctl_pkg::*;
#(
  parameter int ALE_T  = 2,
  parameter int HOLD_T = 1,
  parameter int STB_T  = 4,
  parameter int REC_T  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        bus_wait,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic        busclk,
  output logic        ready,
  output logic [7:0]  rdata
);
  localparam int BUS_T = ALE_T + HOLD_T + STB_T + REC_T;
  localparam int PW    = $clog2(BUS_T);

  logic [PW-1:0] phase;
  logic          period_end, wait_smp, we_q, rd_capture;
  logic [15:0]   addr_q;
  logic [7:0]    wdata_q;
  bus_state_e    state;

  busctl_phase #(.BUS_T(BUS_T), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .busclk(busclk),
    .period_end(period_end), .wait_smp(wait_smp));

  busctl_seq #(.ALE_T(ALE_T), .HOLD_T(HOLD_T), .STB_T(STB_T), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .phase(phase), .period_end(period_end),
    .wait_smp(wait_smp), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .bus_wait(bus_wait), .state(state), .we_q(we_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .ready(ready), .rd_capture(rd_capture));

  busctl_pad u_pad (
    .clk(clk), .rst_n(rst_n), .state(state), .we_q(we_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .rd_capture(rd_capture), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata));

  // R10
  latch_on_busclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $rose(busclk));

endmodule

// File: tb/busctl_mux_test.sv
module busctl_mux_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        bus_wait;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out, addr_hi, rdata;
  logic        ad_oe, ale, rd_n, wr_n, busclk, ready;

  typedef struct {
    logic [15:0] a;
    logic        w;
    logic [7:0]  d;
    int          waits;
  } item_t;

  item_t       exp_q[$];
  int          compared = 0, mismatched = 0;
  int          waits_left = 0;
  logic [15:0] cur_addr = '0;

  function automatic logic [7:0] rsp(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign bus_wait = (waits_left > 0);
  assign ad_in    = !rd_n ? rsp(cur_addr) : 8'h00;

  busctl_mux uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .bus_wait(bus_wait), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .busclk(busclk),
    .ready(ready), .rdata(rdata));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // driver: pushes the expected item, then runs the request handshake
  task automatic run_txn(input logic [15:0] a, input logic w, input logic [7:0] d,
                         input int waits, input int skew);
    item_t it;
    repeat (skew) @(negedge clk);
    it.a = a; it.w = w; it.d = d; it.waits = waits;
    exp_q.push_back(it);
    cur_addr = a; waits_left = waits;
    addr = a; we = w; wdata = d; req = 1'b1;
    do @(negedge clk); while (!ready);
    req = 1'b0;
  endtask

  // monitor: follows the bus tick by tick and compares against the queue head
  initial begin
    logic  p_ale, p_bc, p_stb, p_rdy, stb;
    int    t, t_bc_rise, t_bc_fall, t_ale_rise, t_ale_fall, t_stb_fall, t_stb_rise;
    item_t cur;
    p_ale = 0; p_bc = 0; p_stb = 0; p_rdy = 0; t = 0;
    t_bc_rise = -1; t_bc_fall = -1; t_ale_rise = -100; t_ale_fall = -100;
    t_stb_fall = -100; t_stb_rise = -100;
    cur = '{a: 16'h0, w: 1'b0, d: 8'h0, waits: 0};
    @(posedge rst_n);
    @(negedge clk);
    p_bc = busclk;
    forever begin
      @(negedge clk);
      t++;
      if (exp_q.size() > 0) cur = exp_q[0];
      stb = !rd_n || !wr_n;
      if (busclk && !p_bc) begin
        if (t_bc_rise >= 0) chk((t - t_bc_rise) == 8, "R2 busclk period", t - t_bc_rise, 8);
        if (t_bc_fall >= 0) chk((t - t_bc_fall) == 4, "R2 busclk low", t - t_bc_fall, 4);
        t_bc_rise = t;
      end
      if (!busclk && p_bc) begin
        if (t_bc_rise >= 0) chk((t - t_bc_rise) == 4, "R2 busclk high", t - t_bc_rise, 4);
        t_bc_fall = t;
        if (stb && waits_left > 0) waits_left--;
      end
      if (ale && !p_ale) begin
        chk(busclk && !p_bc, "R10 ale with busclk rise", busclk, 1);
        chk(ad_oe && ad_out == cur.a[7:0], "R3 low address", ad_out, cur.a[7:0]);
        chk(addr_hi == cur.a[15:8], "R3 high address", addr_hi, cur.a[15:8]);
        t_ale_rise = t;
      end
      if (!ale && p_ale) begin
        chk((t - t_ale_rise) == 2, "R3 ale width", t - t_ale_rise, 2);
        chk(ad_oe && ad_out == cur.a[7:0], "R4 address hold", ad_out, cur.a[7:0]);
        chk(rd_n && wr_n, "R4 strobes idle in hold", {rd_n, wr_n}, 3);
        t_ale_fall = t;
      end
      if (stb && !p_stb) begin
        chk((t - t_ale_fall) == 1, "R5 strobe delay", t - t_ale_fall, 1);
        chk(cur.w ? (!wr_n && rd_n) : (!rd_n && wr_n), "R5 strobe select",
            {rd_n, wr_n}, cur.w ? 2 : 1);
        t_stb_fall = t;
      end
      if (stb) begin
        chk(addr_hi == cur.a[15:8], "R3 high address held", addr_hi, cur.a[15:8]);
        if (cur.w) chk(ad_oe && ad_out == cur.d, "R6 write data", ad_out, cur.d);
        else       chk(!ad_oe, "R7 bus released", ad_oe, 0);
      end
      if (!stb && p_stb) begin
        chk((t - t_stb_fall) == 4 + 8 * cur.waits, "R8 strobe width",
            t - t_stb_fall, 4 + 8 * cur.waits);
        chk(!ale, "R9 ale low in recovery", ale, 0);
        if (cur.w) chk(ad_oe && ad_out == cur.d, "R6 write hold", ad_out, cur.d);
        else       chk(!ad_oe, "R7 released in recovery", ad_oe, 0);
        t_stb_rise = t;
      end
      if (p_rdy) chk(!ready, "R9 ready single tick", ready, 0);
      if (ready) begin
        chk((t - t_stb_rise) == 1, "R9 ready timing", t - t_stb_rise, 1);
        if (exp_q.size() == 0) chk(0, "R9 unexpected ready", 1, 0);
        else begin
          cur = exp_q.pop_front();
          if (!cur.w) chk(rdata == rsp(cur.a), "R7 read data", rdata, rsp(cur.a));
        end
      end
      p_ale = ale; p_bc = busclk; p_stb = stb; p_rdy = ready;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at rest while reset is held
    chk(!ale && rd_n && wr_n && !ad_oe && !ready, "R1 reset state",
        {ale, rd_n, wr_n, ad_oe, ready}, 5'b01100);
    @(negedge clk) rst_n = 1'b1;
    run_txn(16'h1234, 1'b1, 8'h5C, 0, 1);
    run_txn(16'h1234, 1'b0, 8'h00, 0, 3);
    run_txn(16'h0000, 1'b0, 8'h00, 0, 2);
    run_txn(16'hFFFF, 1'b1, 8'hFF, 0, 5);
    run_txn(16'hA55A, 1'b1, 8'h00, 1, 1);   // R8 one wait sample
    run_txn(16'h8001, 1'b0, 8'h00, 2, 4);   // R8 two wait samples
    run_txn(16'h7F80, 1'b0, 8'h00, 1, 7);
    run_txn(16'h00FF, 1'b1, 8'h3C, 3, 2);
    for (int i = 0; i < 6; i++)
      run_txn(16'h0101 * (i + 3), i[0], 8'h11 * i, i % 3, i + 1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all items completed", exp_q.size(), 0);
    finish_run();
  end

endmodule